// File: doc/BRIEF.md
# Two-of-Eight Keypad Press Validator

This block reads a telephone-style keypad in which every key closes two switches at once: one of four row lines and one of four column lines. No scanning is needed; the eight switch levels are sampled directly. Each level passes through a two-stage synchroniser. The block then decides, separately for the row group and for the column group, whether exactly one line is closed.

For each group, a set of six pairwise AND terms flags a double press. If no line is closed, the group is invalid but no double press is flagged. A group that is valid presents its line on a one-hot select output, which a downstream tone generator uses to choose a frequency. A group that is invalid drives its select to zero, which mutes that tone. A key-valid flag is raised only when both groups are valid at once. All four column lines are honoured, including the fourth, which most keypads leave unpopulated. Debounce and tone synthesis belong to neighbouring blocks.

Top module: `keypad_2of8_validator`

## Requirements
- R1: While `rst` is high, and on the first output sample after it falls, every output is zero.
- R2: When exactly one row line is high, `row_ok` is 1 and `row_sel` equals the row inputs (bit i of `row_sel` follows bit i of `row_sw`).
- R3: When two or more row lines are high, `row_ok` is 0 and `row_sel` is all zero.
- R4: When no line of a group is high, that group's valid flag and select are 0, and the group is not counted as a double press.
- R5: When exactly one column line is high, including the fourth line (bit 3), `col_ok` is 1 and `col_sel` equals the column inputs.
- R6: When two or more column lines are high, or none is high, `col_ok` is 0 and `col_sel` is all zero.
- R7: `key_ok` is 1 exactly when `row_ok` and `col_ok` are both 1.
- R8: A change at the switch inputs reaches the outputs on the third rising clock edge after it is set up: two synchroniser stages and one output register. The outputs do not change on the first two edges.
- R9: The row and column groups are independent. An invalid row group leaves the column outputs unchanged, and an invalid column group leaves the row outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_sw | input | 4 | Row switch levels, asynchronous, 1 = closed |
| col_sw | input | 4 | Column switch levels, asynchronous, 1 = closed |
| row_sel | output | 4 | One-hot row tone select, zero when the row group is invalid |
| col_sel | output | 4 | One-hot column tone select, zero when the column group is invalid |
| row_ok | output | 1 | Exactly one row line is closed |
| col_ok | output | 1 | Exactly one column line is closed |
| key_ok | output | 1 | Both groups are valid |

## Verification
All sixteen single-key combinations are driven, which separates a correct line-to-select mapping from swapped or dropped bits, including the fourth column. Every two-line pair in each group is driven against a valid partner group. This shows whether each of the six pairwise terms is present, and whether one group's fault leaks into the other. The all-open and all-closed patterns separate "no press" from "multiple press". Random eight-bit patterns then mix every count of closed lines. A held-pattern step checks that the outputs stay unchanged for two edges and move on the third.

// File: rtl/keypad_2of8_pkg.sv
package keypad_2of8_pkg;

    localparam int KP_LINES = 4;

    typedef struct packed {
        logic one;
        logic multi;
        logic none;
    } grp_status_t;

    typedef struct packed {
        logic [KP_LINES-1:0] sel;
        logic                ok;
    } grp_out_t;

    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    function automatic int pair_index(input int i, input int j, input int n);
        return i * n - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/kp_group_check.sv
module kp_group_check
    import keypad_2of8_pkg::*;
#(
    parameter int LINES = KP_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] lines,
    output grp_status_t      status
);
    localparam int NPAIRS = pair_count(LINES);

    logic [NPAIRS-1:0] pair_hit;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_a
            for (genvar j = i + 1; j < LINES; j++) begin : g_b
                localparam int K = pair_index(i, j, LINES);
                assign pair_hit[K] = lines[i] & lines[j];
            end
        end
    endgenerate

    always_comb begin
        status.multi = |pair_hit;
        status.none  = ~(|lines);
        status.one   = ~status.multi & ~status.none;
    end

    // R4: an empty group is never reported as a double press
    assert_none_not_multi_R4: assert property (@(posedge clk) disable iff (rst)
        !(status.none && status.multi));

    // R2: a single-line verdict agrees with a population count of the lines
    assert_one_is_single_R2: assert property (@(posedge clk) disable iff (rst)
        status.one == ($countones(lines) == 1));

    // R3: two or more lines always trip a pairwise term
    assert_multi_count_R3: assert property (@(posedge clk) disable iff (rst)
        ($countones(lines) >= 2) |-> status.multi);
endmodule

// File: rtl/keypad_2of8_validator.sv
module keypad_2of8_validator
    import keypad_2of8_pkg::*;
#(
    parameter int LINES       = KP_LINES,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] row_sw,
    input  logic [LINES-1:0] col_sw,
    output logic [LINES-1:0] row_sel,
    output logic [LINES-1:0] col_sel,
    output logic             row_ok,
    output logic             col_ok,
    output logic             key_ok
);
    localparam int NGRP = 2;
    localparam int GRP_ROW = 0;
    localparam int GRP_COL = 1;

    logic [LINES-1:0] raw_lines  [NGRP];
    logic [LINES-1:0] sync_lines [NGRP];
    grp_status_t      grp_stat   [NGRP];
    logic [LINES-1:0] sel_q      [NGRP];
    logic             ok_q       [NGRP];
    logic             key_q;

    assign raw_lines[GRP_ROW] = row_sw;
    assign raw_lines[GRP_COL] = col_sw;

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            kp_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst    (rst),
                .d_async(raw_lines[g]),
                .q_sync (sync_lines[g])
            );

            kp_group_check #(.LINES(LINES)) u_chk (
                .clk   (clk),
                .rst   (rst),
                .lines (sync_lines[g]),
                .status(grp_stat[g])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q[g] <= '0;
                    ok_q[g]  <= 1'b0;
                end else begin
                    sel_q[g] <= grp_stat[g].one ? sync_lines[g] : '0;
                    ok_q[g]  <= grp_stat[g].one;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) key_q <= 1'b0;
        else     key_q <= grp_stat[GRP_ROW].one & grp_stat[GRP_COL].one;
    end

    assign row_sel = sel_q[GRP_ROW];
    assign col_sel = sel_q[GRP_COL];
    assign row_ok  = ok_q[GRP_ROW];
    assign col_ok  = ok_q[GRP_COL];
    assign key_ok  = key_q;

    // R3: an invalid row group never drives a tone select
    assert_row_mute_R3: assert property (@(posedge clk) disable iff (rst)
        !row_ok |-> (row_sel == '0));

    // R6: an invalid column group never drives a tone select
    assert_col_mute_R6: assert property (@(posedge clk) disable iff (rst)
        !col_ok |-> (col_sel == '0));

    // R7: a valid key implies a single select in each group
    assert_key_both_R7: assert property (@(posedge clk) disable iff (rst)
        key_ok |-> ($onehot(row_sel) && $onehot(col_sel)));

    // R8: the row verdict reflects the synchronised lines one edge earlier
    assert_row_latency_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (row_ok == ($countones($past(sync_lines[GRP_ROW])) == 1)));

    // R8: same for columns
    assert_col_latency_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (col_ok == ($countones($past(sync_lines[GRP_COL])) == 1)));
endmodule

// File: tb/keypad_2of8_validator_bench.sv
module keypad_2of8_validator_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] row_sw = '0;
    logic [3:0] col_sw = '0;
    logic [3:0] row_sel, col_sel;
    logic       row_ok, col_ok, key_ok;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keypad_2of8_validator u_keypad_2of8_validator (
        .clk(clk), .rst(rst), .row_sw(row_sw), .col_sw(col_sw),
        .row_sel(row_sel), .col_sel(col_sel),
        .row_ok(row_ok), .col_ok(col_ok), .key_ok(key_ok)
    );

    function automatic bit exp_ok(input logic [3:0] v);
        return $countones(v) == 1;
    endfunction

    function automatic logic [3:0] exp_sel(input logic [3:0] v);
        return exp_ok(v) ? v : 4'b0000;
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic check_all(input string req, input logic [3:0] r, input logic [3:0] c);
        check({req, " row_sel"}, int'(row_sel), int'(exp_sel(r)));
        check({req, " row_ok"},  int'(row_ok),  int'(exp_ok(r)));
        check({req, " col_sel"}, int'(col_sel), int'(exp_sel(c)));
        check({req, " col_ok"},  int'(col_ok),  int'(exp_ok(c)));
        check({req, " key_ok R7"}, int'(key_ok), int'(exp_ok(r) && exp_ok(c)));
    endtask

    task automatic apply(input string req, input logic [3:0] r, input logic [3:0] c);
        @(negedge clk);
        row_sw = r;
        col_sw = c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(req, r, c);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_2a08);
        row_sw = 4'b0101;
        col_sw = 4'b0010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1 row_sel", int'(row_sel), 0);
        check("R1 col_sel", int'(col_sel), 0);
        check("R1 flags", int'({row_ok, col_ok, key_ok}), 0);
        row_sw = '0;
        col_sw = '0;
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 first sample after reset", int'({row_sel, col_sel, row_ok, col_ok, key_ok}), 0);

        // R2 R5: every single key, including the fourth column
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                apply("R2 R5 single key", 4'(1 << i), 4'(1 << j));

        // R3 R9: each row pair with a valid column
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                apply("R3 R9 row pair", 4'((1 << i) | (1 << j)), 4'b1000);

        // R6 R9: each column pair with a valid row
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                apply("R6 R9 col pair", 4'b0001, 4'((1 << i) | (1 << j)));

        // R4: empty groups
        apply("R4 no row", 4'b0000, 4'b0100);
        apply("R4 R6 no col", 4'b0010, 4'b0000);
        apply("R4 nothing", 4'b0000, 4'b0000);
        apply("R3 R6 all closed", 4'b1111, 4'b1111);
        apply("R3 three rows", 4'b1110, 4'b0001);

        // R8: latency of exactly three edges
        apply("R8 setup", 4'b0001, 4'b0001);
        @(negedge clk);
        row_sw = 4'b0100;
        col_sw = 4'b1000;
        @(posedge clk);
        @(negedge clk);
        check("R8 edge1 row_sel", int'(row_sel), 1);
        @(posedge clk);
        @(negedge clk);
        check("R8 edge2 col_sel", int'(col_sel), 1);
        @(posedge clk);
        @(negedge clk);
        check("R8 edge3 row_sel", int'(row_sel), 4);
        check("R8 edge3 col_sel", int'(col_sel), 8);

        // random mix
        for (int n = 0; n < 200; n++) begin
            logic [7:0] v;
            v = 8'($urandom);
            apply("R2 R3 R5 R6 R7 random", v[3:0], v[7:4]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule